// File: doc/BRIEF.md
# Byte FIFO DMA Port with Transfer Counter

This block is the device end of a byte-wide DMA link. A 16-entry byte FIFO sits between a host data port and a device-side byte stream that uses valid/ready handshakes. The direction input selects how the FIFO is used. When data flows toward the host, the stream fills the FIFO and the host drains it. When data flows from the host, the host fills the FIFO and the stream drains it.

The host reaches the FIFO in two ways. The first is a DMA acknowledge strobe. Each such access decrements a loadable transfer counter, and the counter raises an interrupt when it reaches zero. The second is a register access: chip-select active with the FIFO address. Each register access raises its own interrupt. A request output tells a DMA engine, or a polling loop, when another acknowledge access may be made.

An external phase-change event also raises the interrupt, and it takes precedence over the other causes. Reading the status register clears the interrupt.

Top module: `dfp_port`

## Requirements
- R1: After a synchronous reset, `dreq` and `irq` are 0, the counter is 0, and a read of the status register returns 0x00.
- R2: The FIFO holds up to 16 bytes and delivers them in arrival order. When data flows toward the host, `s_in_ready` is 0 while 16 bytes are held, and a stream byte offered then is dropped.
- R3: With `dir_to_host` = 1, `dreq` is 1 exactly when the FIFO holds at least one byte and the counter is nonzero. `dreq` reflects the state after each clock edge, so it falls to 0 once the counter reaches zero.
- R4: With `dir_to_host` = 0, `dreq` is 1 exactly when the FIFO holds fewer than 16 bytes and the counter is nonzero.
- R5: A register write to address 0 loads the low byte of the counter, and a write to address 1 loads the high byte. Reads of these addresses return the bytes. The counter decrements once for each acknowledge access that moves a byte. It never drops below zero. Acknowledge accesses that move no byte (read of an empty FIFO, write to a full FIFO, wrong direction) leave the counter unchanged. Register accesses never change the counter.
- R6: When an acknowledge access takes the counter from 1 to 0, `irq` rises at that edge and the cause code becomes 2 (transfer complete).
- R7: A register read or write at address 2 (chip-select active, acknowledge inactive) pops or pushes one FIFO byte and raises `irq` with cause code 1.
- R8: A `phase_evt` pulse raises `irq` with cause code 3. A pending code is only replaced by a higher one. Phase change (3) therefore wins over transfer complete (2) when both occur in the same cycle, and a later register FIFO access (1) does not replace a pending 2 or 3.
- R9: If chip-select and acknowledge are asserted in the same cycle, a sticky error flag is set and stays set until reset. That cycle changes neither the FIFO nor the counter.
- R10: A read of address 3 returns a status byte: bit 7 is `irq`, bit 6 is the error flag, bits 1:0 are the cause code, and all other bits are 0. The read clears `irq` and the cause code at the same edge, unless a new event arrives in that cycle. The error flag is not cleared. Register read data appears on `rdata` after the clock edge that samples the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_to_host | input | 1 | 1: stream to host; 0: host to stream |
| cs | input | 1 | Register chip-select |
| ack | input | 1 | DMA acknowledge strobe (FIFO access) |
| rd | input | 1 | Host read |
| wr | input | 1 | Host write |
| addr | input | 4 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, registered |
| dreq | output | 1 | DMA request |
| irq | output | 1 | Interrupt |
| s_in_valid | input | 1 | Stream byte offered to FIFO |
| s_in_data | input | 8 | Stream input byte |
| s_in_ready | output | 1 | FIFO can take a stream byte |
| s_out_valid | output | 1 | FIFO byte offered to stream |
| s_out_data | output | 8 | Stream output byte |
| s_out_ready | input | 1 | Stream takes the offered byte |
| phase_evt | input | 1 | Phase-change event pulse |

## Verification
The assertions check several rules on every cycle:
- the FIFO level stays within 16, and the stream input is refused when the FIFO is full;
- `dreq` is never high while the counter is zero;
- a counter step from 1 to 0 always leaves a pending code of at least 2;
- a phase event always yields code 3;
- a clearing status read lowers `irq`;
- the error flag is sticky, and a clash cycle never moves the counter.

Other behaviour shows up only in the bench's scenarios:
- byte ordering through both directions;
- data loss when the FIFO is full;
- the exact status byte values, including the priority merging of causes;
- the fact that a clash cycle leaves the next FIFO byte in place.

// File: rtl/dfp_pkg.sv
package dfp_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 4'h0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 4'h1;
  localparam logic [ADDR_W-1:0] A_FIFO   = 4'h2;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'h3;
  localparam logic [1:0] CAUSE_NONE  = 2'd0;
  localparam logic [1:0] CAUSE_PIO   = 2'd1;
  localparam logic [1:0] CAUSE_DONE  = 2'd2;
  localparam logic [1:0] CAUSE_PHASE = 2'd3;
endpackage

// File: rtl/dfp_fifo.sv
module dfp_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  level_nx,
  output logic              empty,
  output logic              full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  assign head     = mem[rptr];
  assign empty    = (level == '0);
  assign full     = (level == LVL_W'(DEPTH));
  assign level_nx = level + LVL_W'(push) - LVL_W'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= step(wptr);
      if (pop)  rptr <= step(rptr);
      level <= level_nx;
    end
  end
endmodule

// File: rtl/dfp_xfer_count.sv
module dfp_xfer_count #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              dec,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cnt_nx,
  output logic              tc
);
  localparam logic [CNT_W-1:0] LO_MASK = CNT_W'({DATA_W{1'b1}});

  assign tc = dec && (cnt == CNT_W'(1));

  always_comb begin
    cnt_nx = cnt;
    if (ld_lo)
      cnt_nx = (cnt & ~LO_MASK) | CNT_W'(ld_data);
    else if (ld_hi)
      cnt_nx = (cnt & LO_MASK) | (CNT_W'(ld_data) << DATA_W);
    else if (dec && cnt != '0)
      cnt_nx = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nx;
  end
endmodule

// File: rtl/dfp_irq.sv
module dfp_irq
  import dfp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ev_pio,
  input  logic       ev_done,
  input  logic       ev_phase,
  input  logic       clr,
  output logic [1:0] code,
  output logic       irq
);
  logic [1:0] new_c, merged;

  always_comb begin
    if (ev_phase)     new_c = CAUSE_PHASE;
    else if (ev_done) new_c = CAUSE_DONE;
    else if (ev_pio)  new_c = CAUSE_PIO;
    else              new_c = CAUSE_NONE;
    if (clr)                merged = new_c;
    else if (new_c > code)  merged = new_c;
    else                    merged = code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= CAUSE_NONE;
      irq  <= 1'b0;
    end else begin
      code <= merged;
      irq  <= (merged != CAUSE_NONE);
    end
  end
endmodule

// File: rtl/dfp_port.sv
module dfp_port
  import dfp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dir_to_host,
  input  logic              cs,
  input  logic              ack,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              dreq,
  output logic              irq,
  input  logic              s_in_valid,
  input  logic [DATA_W-1:0] s_in_data,
  output logic              s_in_ready,
  output logic              s_out_valid,
  output logic [DATA_W-1:0] s_out_data,
  input  logic              s_out_ready,
  input  logic              phase_evt
);
  logic              clash, dma_acc, reg_acc, pio_acc;
  logic              host_rd_fifo, host_wr_fifo, host_pop, host_push;
  logic              ser_push, ser_pop, f_push, f_pop, dec;
  logic              ld_lo, ld_hi, stat_rd, tc;
  logic              empty, full, err_q;
  logic [DATA_W-1:0] head, push_data;
  logic [LVL_W-1:0]  lvl_q, lvl_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [1:0]        code_q;

  // host access decode
  assign clash        = cs && ack;
  assign dma_acc      = ack && !cs && (rd || wr);
  assign reg_acc      = cs && !ack && (rd || wr);
  assign pio_acc      = reg_acc && (addr == A_FIFO);
  assign host_rd_fifo = (dma_acc || pio_acc) && rd;
  assign host_wr_fifo = (dma_acc || pio_acc) && wr && !rd;
  assign host_pop     = host_rd_fifo && dir_to_host && !empty;
  assign host_push    = host_wr_fifo && !dir_to_host && !full;
  assign dec          = dma_acc && (host_pop || host_push);
  assign ld_lo        = reg_acc && wr && !rd && (addr == A_CNT_LO);
  assign ld_hi        = reg_acc && wr && !rd && (addr == A_CNT_HI);
  assign stat_rd      = reg_acc && rd && (addr == A_STAT);

  // stream side
  assign s_in_ready  = dir_to_host && !full;
  assign s_out_valid = !dir_to_host && !empty;
  assign s_out_data  = head;
  assign ser_push    = s_in_valid && s_in_ready;
  assign ser_pop     = s_out_valid && s_out_ready;

  assign f_push    = ser_push || host_push;
  assign f_pop     = ser_pop || host_pop;
  assign push_data = dir_to_host ? s_in_data : wdata;

  dfp_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(f_push), .push_data(push_data), .pop(f_pop),
    .head(head), .level(lvl_q), .level_nx(lvl_nx), .empty(empty), .full(full)
  );

  dfp_xfer_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_data(wdata),
    .dec(dec), .cnt(cnt_q), .cnt_nx(cnt_nx), .tc(tc)
  );

  dfp_irq u_irq (
    .clk(clk), .rst(rst), .ev_pio(pio_acc), .ev_done(tc), .ev_phase(phase_evt),
    .clr(stat_rd), .code(code_q), .irq(irq)
  );

  // registered outputs, request computed from post-edge state
  always_ff @(posedge clk) begin
    if (rst) begin
      dreq  <= 1'b0;
      err_q <= 1'b0;
      rdata <= '0;
    end else begin
      dreq <= (cnt_nx != '0) &&
              (dir_to_host ? (lvl_nx != '0) : (lvl_nx != LVL_W'(DEPTH)));
      if (clash) err_q <= 1'b1;
      if (host_rd_fifo) begin
        rdata <= (dir_to_host && !empty) ? head : '0;
      end else if (reg_acc && rd) begin
        case (addr)
          A_CNT_LO: rdata <= DATA_W'(cnt_q);
          A_CNT_HI: rdata <= DATA_W'(cnt_q >> DATA_W);
          A_STAT:   rdata <= {irq, err_q, {(DATA_W-4){1'b0}}, code_q};
          default:  rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dfp_port_chk.sv
module dfp_port_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cs,
  input logic             ack,
  input logic             rd,
  input logic [3:0]       addr,
  input logic             phase_evt,
  input logic             dreq,
  input logic             irq,
  input logic             s_in_ready,
  input logic [CNT_W-1:0] cnt,
  input logic [LVL_W-1:0] level,
  input logic [1:0]       code,
  input logic             err
);
  assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));

  assert_full_refuses_R2: assert property (@(posedge clk) disable iff (rst)
    (level == LVL_W'(DEPTH)) |-> !s_in_ready);

  assert_dreq_needs_count_R3: assert property (@(posedge clk) disable iff (rst)
    dreq |-> (cnt != '0));

  assert_tc_raises_irq_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && $past(cnt) == CNT_W'(1) && !$past(cs)) |-> (irq && code >= 2'd2));

  assert_phase_code_R8: assert property (@(posedge clk) disable iff (rst)
    phase_evt |=> (irq && code == 2'd3));

  assert_clash_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (cs && ack) |=> err);

  assert_err_holds_R9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_clash_keeps_count_R9: assert property (@(posedge clk) disable iff (rst)
    (cs && ack) |=> (cnt == $past(cnt)));

  assert_status_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (cs && !ack && rd && addr == 4'h3 && !phase_evt) |=> !irq);
endmodule

bind dfp_port dfp_port_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .ack(ack), .rd(rd), .addr(addr),
  .phase_evt(phase_evt), .dreq(dreq), .irq(irq), .s_in_ready(s_in_ready),
  .cnt(cnt_q), .level(lvl_q), .code(code_q), .err(err_q)
);

// File: tb/dfp_port_tb.sv
module dfp_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dir_to_host = 1'b1;
  logic       cs = 0, ack = 0, rd = 0, wr = 0, phase_evt = 0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata, s_in_data = '0, s_out_data;
  logic       dreq, irq, s_in_valid = 0, s_in_ready, s_out_valid, s_out_ready = 0;

  int checks = 0, fails = 0;
  logic [7:0] host_q[$];
  logic [7:0] ser_q[$];
  bit rd_pend = 0;

  always #2.5 clk = ~clk;

  dfp_port u_dut (
    .clk(clk), .rst(rst), .dir_to_host(dir_to_host), .cs(cs), .ack(ack),
    .rd(rd), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata), .dreq(dreq),
    .irq(irq), .s_in_valid(s_in_valid), .s_in_data(s_in_data),
    .s_in_ready(s_in_ready), .s_out_valid(s_out_valid), .s_out_data(s_out_data),
    .s_out_ready(s_out_ready), .phase_evt(phase_evt)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares FIFO bytes seen by host and by stream with the scoreboard
  always @(posedge clk) begin
    logic [7:0] e;
    if (rd_pend) begin
      if (host_q.size() == 0) chk(0, "R2 host byte without expectation", rdata, 0);
      else begin e = host_q.pop_front(); chk(rdata == e, "R2 host byte order", rdata, e); end
    end
    rd_pend = !rst && dir_to_host && rd &&
              ((ack && !cs) || (cs && !ack && addr == 4'h2));
    if (!rst && s_out_valid && s_out_ready) begin
      if (ser_q.size() == 0) chk(0, "R2 stream byte without expectation", s_out_data, 0);
      else begin e = ser_q.pop_front(); chk(s_out_data == e, "R2 stream byte order", s_out_data, e); end
    end
  end

  task automatic ser_push(input logic [7:0] b, input bit taken);
    @(negedge clk); s_in_valid = 1; s_in_data = b;
    if (taken) host_q.push_back(b);
    @(negedge clk); s_in_valid = 0;
  endtask

  task automatic dma_rd();
    @(negedge clk); ack = 1; rd = 1;
    @(negedge clk); ack = 0; rd = 0;
  endtask

  task automatic dma_wr(input logic [7:0] b, input bit taken);
    @(negedge clk); ack = 1; wr = 1; wdata = b;
    if (taken) ser_q.push_back(b);
    @(negedge clk); ack = 0; wr = 0;
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(negedge clk); cs = 0; rd = 0; d = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(dreq == 0, "R1 dreq after reset", dreq, 0);
    chk(irq == 0, "R1 irq after reset", irq, 0);
    reg_rd(4'h3, d); chk(d == 8'h00, "R1 status after reset", d, 8'h00);
    reg_rd(4'h0, d); chk(d == 8'h00, "R1 count after reset", d, 8'h00);

    // toward host
    reg_wr(4'h0, 8'd3); reg_wr(4'h1, 8'd0);
    reg_rd(4'h0, d); chk(d == 8'd3, "R5 count low readback", d, 3);
    reg_rd(4'h1, d); chk(d == 8'd0, "R5 count high readback", d, 0);
    chk(dreq == 0, "R3 dreq low on empty FIFO", dreq, 0);
    for (int i = 0; i < 16; i++) ser_push(8'h10 + 8'(i), 1);
    chk(s_in_ready == 0, "R2 stream refused when full", s_in_ready, 0);
    chk(dreq == 1, "R3 dreq with data and count", dreq, 1);
    ser_push(8'hEE, 0);
    for (int i = 0; i < 3; i++) dma_rd();
    chk(dreq == 0, "R3 dreq forced low at zero count", dreq, 0);
    chk(irq == 1, "R6 irq at terminal count", irq, 1);
    reg_rd(4'h0, d); chk(d == 8'd0, "R5 count reached zero", d, 0);
    reg_rd(4'h3, d); chk(d == 8'h82, "R6 status done code", d, 8'h82);
    chk(irq == 0, "R10 irq cleared by status read", irq, 0);
    reg_rd(4'h3, d); chk(d == 8'h00, "R10 cause cleared", d, 8'h00);

    // register FIFO access
    reg_wr(4'h0, 8'd2);
    reg_rd(4'h2, d); chk(d == 8'h13, "R7 register FIFO read byte", d, 8'h13);
    chk(irq == 1, "R7 irq on register FIFO access", irq, 1);
    reg_rd(4'h0, d); chk(d == 8'd2, "R5 register access keeps count", d, 2);
    reg_rd(4'h3, d); chk(d == 8'h81, "R7 status register-access code", d, 8'h81);

    // priority
    reg_wr(4'h0, 8'd1);
    @(negedge clk); ack = 1; rd = 1; phase_evt = 1;
    @(negedge clk); ack = 0; rd = 0; phase_evt = 0;
    reg_rd(4'h3, d); chk(d == 8'h83, "R8 phase beats done same cycle", d, 8'h83);
    reg_wr(4'h0, 8'd1);
    dma_rd();
    reg_rd(4'h2, d);
    reg_rd(4'h3, d); chk(d == 8'h82, "R8 pending done kept over register access", d, 8'h82);
    @(negedge clk); phase_evt = 1;
    @(negedge clk); phase_evt = 0;
    reg_rd(4'h2, d);
    reg_rd(4'h3, d); chk(d == 8'h83, "R8 pending phase kept", d, 8'h83);

    // clash
    reg_wr(4'h0, 8'd5);
    @(negedge clk); cs = 1; ack = 1; rd = 1; addr = 4'h2;
    @(negedge clk); cs = 0; ack = 0; rd = 0;
    reg_rd(4'h0, d); chk(d == 8'd5, "R9 clash leaves count", d, 5);
    reg_rd(4'h3, d); chk(d == 8'h40, "R9 error flag set", d, 8'h40);
    reg_rd(4'h3, d); chk(d == 8'h40, "R9 error flag sticky", d, 8'h40);
    dma_rd();
    reg_rd(4'h0, d); chk(d == 8'd4, "R5 dma read decrements", d, 4);

    // drain rest
    @(negedge clk);
    n = host_q.size();
    chk(n == 7, "R2 bytes left in FIFO", n, 7);
    repeat (n) reg_rd(4'h2, d);
    @(negedge clk);
    reg_rd(4'h3, d); chk(d == 8'hC1, "R10 status with error and code", d, 8'hC1);

    // from host
    @(negedge clk); dir_to_host = 0; s_out_ready = 0;
    reg_wr(4'h0, 8'd20); reg_wr(4'h1, 8'd0);
    chk(dreq == 1, "R4 dreq with room and count", dreq, 1);
    chk(s_out_valid == 0, "R2 no stream byte on empty FIFO", s_out_valid, 0);
    for (int i = 0; i < 16; i++) dma_wr(8'hA0 + 8'(i), 1);
    chk(dreq == 0, "R4 dreq low when full", dreq, 0);
    reg_rd(4'h0, d); chk(d == 8'd4, "R5 count after 16 writes", d, 4);
    dma_wr(8'hEE, 0);
    reg_rd(4'h0, d); chk(d == 8'd4, "R5 write to full FIFO ignored", d, 4);
    @(negedge clk); s_out_ready = 1;
    repeat (20) @(negedge clk);
    chk(ser_q.size() == 0, "R2 all stream bytes delivered", ser_q.size(), 0);
    chk(dreq == 1, "R4 dreq back after drain", dreq, 1);
    ser_q.push_back(8'h55);
    reg_wr(4'h2, 8'h55);
    repeat (3) @(negedge clk);
    chk(ser_q.size() == 0, "R7 register write delivered", ser_q.size(), 0);
    reg_rd(4'h3, d); chk(d == 8'hC1, "R7 register write raises code", d, 8'hC1);
    @(negedge clk);
    chk(host_q.size() == 0, "R2 host scoreboard empty", host_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule